// File: doc/BRIEF.md
# Memory Bank Window Decoder

This block turns a physical address into a RAM hit, a bank number and a byte offset into that bank's installed storage. Software programs two 32-bit configuration words, each covering two of the four banks, to set each bank's base, window size, enable and rank layout. A static strap input, one nibble per bank, tells the block how much memory is actually fitted in each bank and whether that memory has one rank or two.

The decode is resolved while it runs. When the installed memory is smaller than the programmed window, the memory repeats throughout the window. When two ranks are programmed, the window splits into two halves, one per rank. When the programmed and fitted rank counts disagree, either half of the window maps to nothing or the second fitted rank cannot be reached. The first 512 KiB of the bank based at 0x0800_0000 also appears at address zero. An address that no bank claims raises a miss output, which the surrounding fabric can turn into a bus error.

The configuration words are written through a simple strobe with a one-bit word select and read back through a separate select. The decode path is purely combinational from the address and the stored words.

Top module: `bank_map_decoder`

## Requirements
- R1: Reset clears both configuration words to zero. After reset both read back as 0 and every address misses.
- R2: A write with `cfg_wr_en` high stores `cfg_wr_data` into the word chosen by `cfg_wr_sel` at the clock edge. `cfg_rd_data` then returns that value for `cfg_rd_sel` equal to the same index. The decode uses the new value from the following cycle.
- R3: Word 0 holds bank 0 in bits 31:16 and bank 1 in bits 15:0. Word 1 holds bank 2 in bits 31:16 and bank 3 in bits 15:0. Within each 16-bit half, the fields are: bits 7:0, the base in 4 MiB units; bits 12:8, a value n that gives a window of (n+1) x 4 MiB; bit 13, enable; bit 14, two programmed ranks.
- R4: `inst_map` bits [4b+3:4b] describe bank b. Bits 2:0 are a code c, where 0 means empty and any other value means 2^(c+21) bytes are fitted. Bit 3 set means the fitted memory has two ranks. A bank whose enable bit is clear, or whose code is 0, claims no address, including the low alias.
- R5: With one programmed rank and one fitted rank, a bank claims [base, base+window). The offset is (addr-base) mod fitted bytes.
- R6: The per-rank window is the window, halved when two ranks are programmed. The per-rank fitted size is the fitted bytes, halved when two ranks are fitted. The effective size is the smaller of the two. With two programmed and two fitted ranks, rank r covers [base+r x rank window, base+(r+1) x rank window). Its offset is ((addr - rank start) mod effective size) + r x effective size.
- R7: With two programmed ranks and one fitted rank, only the first rank window is claimed. The second half of the window misses.
- R8: With one programmed rank and two fitted ranks, the whole window maps onto the first fitted rank. The offset repeats with a period of half the fitted bytes, so the second fitted rank is never reached.
- R9: Addresses below 0x0008_0000 hit an enabled, populated bank whose base field is 0x20 (0x0800_0000). For these addresses the offset equals the address.
- R10: When several banks claim one address, the lowest-numbered bank wins and supplies the offset.
- R11: `hit` and `miss` are always complementary. On a miss, `hit_bank` and `hit_offset` are zero. Any offset reported on a hit is below the fitted bytes of the reported bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 1 | Word index for the write |
| cfg_wr_data | input | 32 | Configuration write data |
| cfg_rd_sel | input | 1 | Word index for readback |
| cfg_rd_data | output | 32 | Readback of the selected word |
| inst_map | input | 16 | Fitted memory per bank, one nibble each, bank 0 lowest |
| probe_addr | input | 32 | Physical address to decode |
| hit | output | 1 | Address maps to RAM |
| miss | output | 1 | Address maps to nothing |
| hit_bank | output | 2 | Winning bank index |
| hit_offset | output | 32 | Byte offset into the bank's fitted storage |

## Verification
The hardest cases to reach from the ports are the mismatched rank layouts: a split window over single-rank memory, and a single window over dual-rank memory. In both, the mapping differs from the naive one only past the mirror period or past the rank midpoint. The stimulus programs one bank at a time into each rank combination with a fitted size well below the window. It then sweeps addresses one byte either side of every power-of-two and rank boundary in the window, and adds random addresses inside the window. Overlap priority and the low alias are forced by giving two banks the same 0x0800_0000 base, so that one address is claimed both through a window and through the alias.

// File: rtl/bmd_pkg.sv
package bmd_pkg;
  // Configuration word layout: two 16-bit bank halves per word.
  localparam int CFG_REG_W  = 32;
  localparam int HALF_W     = CFG_REG_W / 2;
  // One nibble of strap information per bank.
  localparam int INST_NIB_W = 4;
  localparam int INST_CODE_W = 3;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/bmd_cfg_regs.sv
module bmd_cfg_regs
  import bmd_pkg::*;
#(
  parameter int REG_CNT = 2,
  localparam int SEL_W = idx_w(REG_CNT)
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [SEL_W-1:0]                     wr_sel,
  input  logic [CFG_REG_W-1:0]                 wr_data,
  input  logic [SEL_W-1:0]                     rd_sel,
  output logic [CFG_REG_W-1:0]                 rd_data,
  output logic [REG_CNT-1:0][CFG_REG_W-1:0]    regs_q
);

  logic [REG_CNT-1:0][CFG_REG_W-1:0] regs_d;

  // next-state: only the addressed word changes
  always_comb begin
    regs_d = regs_q;
    for (int i = 0; i < REG_CNT; i++) begin
      if (wr_sel == SEL_W'(i)) begin
        regs_d[i] = wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else if (wr_en) begin
      regs_q <= regs_d;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < REG_CNT; i++) begin
      if (rd_sel == SEL_W'(i)) begin
        rd_data = regs_q[i];
      end
    end
  end

endmodule

// File: rtl/bmd_bank_window.sv
module bmd_bank_window
  import bmd_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int BASE_W        = 8,
  parameter int SIZE_W        = 5,
  parameter int UNIT_LOG2     = 22,
  parameter int INST_MIN_LOG2 = 21,
  parameter int ALIAS_LOG2    = 19,
  parameter int ALIAS_BASE    = 32
) (
  input  logic [HALF_W-1:0]     half_cfg,
  input  logic [INST_NIB_W-1:0] inst,
  input  logic [ADDR_W-1:0]     addr,
  output logic                  hit,
  output logic [ADDR_W-1:0]     offset
);

  // field positions inside the 16-bit half
  localparam int SIZE_LSB  = BASE_W;
  localparam int EN_BIT    = BASE_W + SIZE_W;
  localparam int DUAL_BIT  = EN_BIT + 1;
  localparam int W         = ADDR_W + 2;

  logic [BASE_W-1:0]      base_f;
  logic [SIZE_W-1:0]      size_f;
  logic                   en_f;
  logic                   conf_dual;
  logic [INST_CODE_W-1:0] code;
  logic                   inst_dual;
  logic                   active;

  assign base_f    = half_cfg[BASE_W-1:0];
  assign size_f    = half_cfg[SIZE_LSB +: SIZE_W];
  assign en_f      = half_cfg[EN_BIT];
  assign conf_dual = half_cfg[DUAL_BIT];
  assign code      = inst[INST_CODE_W-1:0];
  assign inst_dual = inst[INST_NIB_W-1];
  assign active    = en_f && (code != '0);

  logic [W-1:0] addr_w, base_w, win_full, win_rank, inst_full, inst_rank;
  logic [W-1:0] eff, span, delta, rel, off_full, alias_lim;
  logic         two_ranks, in_win, upper, alias_hit;

  assign addr_w    = W'(addr);
  assign base_w    = W'(base_f) << UNIT_LOG2;
  assign win_full  = (W'(size_f) + W'(1)) << UNIT_LOG2;
  assign win_rank  = conf_dual ? (win_full >> 1) : win_full;
  assign inst_full = W'(1) << (INST_MIN_LOG2 + int'(code));
  assign inst_rank = inst_dual ? (inst_full >> 1) : inst_full;
  assign two_ranks = conf_dual && inst_dual;
  assign eff       = (win_rank < inst_rank) ? win_rank : inst_rank;
  assign span      = two_ranks ? (win_rank << 1) : win_rank;

  assign delta     = addr_w - base_w;
  assign in_win    = active && (addr_w >= base_w) && (delta < span);
  assign upper     = two_ranks && (delta >= win_rank);
  assign rel       = upper ? (delta - win_rank) : delta;
  // fitted rank size is a power of two, so the repeat is a mask
  assign off_full  = (rel & (inst_rank - W'(1))) + (upper ? eff : '0);

  assign alias_lim = W'(1) << ALIAS_LOG2;
  assign alias_hit = active && (base_f == BASE_W'(ALIAS_BASE)) && (addr_w < alias_lim);

  assign hit    = in_win || alias_hit;
  assign offset = in_win ? off_full[ADDR_W-1:0] : (alias_hit ? addr : '0);

  logic unused_sink;
  assign unused_sink = ^{half_cfg, off_full};

endmodule

// File: rtl/bmd_hit_select.sv
module bmd_hit_select
  import bmd_pkg::*;
#(
  parameter int N      = 4,
  parameter int ADDR_W = 32,
  localparam int IDX_W = idx_w(N)
) (
  input  logic [N-1:0]             bank_hit,
  input  logic [N-1:0][ADDR_W-1:0] bank_off,
  output logic                     hit,
  output logic                     miss,
  output logic [IDX_W-1:0]         idx,
  output logic [ADDR_W-1:0]        off
);

  // scan from the top so the lowest index is written last and wins
  always_comb begin
    hit = 1'b0;
    idx = '0;
    off = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (bank_hit[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
        off = bank_off[i];
      end
    end
  end

  assign miss = ~hit;

endmodule

// File: rtl/bank_map_decoder.sv
module bank_map_decoder
  import bmd_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int BANK_CNT      = 4,
  parameter int BASE_W        = 8,
  parameter int SIZE_W        = 5,
  parameter int UNIT_LOG2     = 22,
  parameter int INST_MIN_LOG2 = 21,
  parameter int ALIAS_LOG2    = 19,
  parameter int ALIAS_BASE    = 32,
  localparam int REG_CNT      = BANK_CNT / 2,
  localparam int SEL_W        = idx_w(REG_CNT),
  localparam int IDX_W        = idx_w(BANK_CNT),
  localparam int MAP_W        = BANK_CNT * INST_NIB_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr_en,
  input  logic [SEL_W-1:0]     cfg_wr_sel,
  input  logic [CFG_REG_W-1:0] cfg_wr_data,
  input  logic [SEL_W-1:0]     cfg_rd_sel,
  output logic [CFG_REG_W-1:0] cfg_rd_data,
  input  logic [MAP_W-1:0]     inst_map,
  input  logic [ADDR_W-1:0]    probe_addr,
  output logic                 hit,
  output logic                 miss,
  output logic [IDX_W-1:0]     hit_bank,
  output logic [ADDR_W-1:0]    hit_offset
);

  logic [REG_CNT-1:0][CFG_REG_W-1:0] regs;
  logic [BANK_CNT-1:0]               bank_hit;
  logic [BANK_CNT-1:0][ADDR_W-1:0]   bank_off;

  bmd_cfg_regs #(.REG_CNT(REG_CNT)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_sel  (cfg_wr_sel),
    .wr_data (cfg_wr_data),
    .rd_sel  (cfg_rd_sel),
    .rd_data (cfg_rd_data),
    .regs_q  (regs)
  );

  for (genvar b = 0; b < BANK_CNT; b++) begin : g_bank
    logic [HALF_W-1:0] half;
    // even bank takes the upper half of its word, odd bank the lower
    if (b % 2 == 0) begin : g_hi
      assign half = regs[b/2][CFG_REG_W-1:HALF_W];
    end else begin : g_lo
      assign half = regs[b/2][HALF_W-1:0];
    end

    bmd_bank_window #(
      .ADDR_W        (ADDR_W),
      .BASE_W        (BASE_W),
      .SIZE_W        (SIZE_W),
      .UNIT_LOG2     (UNIT_LOG2),
      .INST_MIN_LOG2 (INST_MIN_LOG2),
      .ALIAS_LOG2    (ALIAS_LOG2),
      .ALIAS_BASE    (ALIAS_BASE)
    ) u_win (
      .half_cfg (half),
      .inst     (inst_map[b*INST_NIB_W +: INST_NIB_W]),
      .addr     (probe_addr),
      .hit      (bank_hit[b]),
      .offset   (bank_off[b])
    );
  end

  bmd_hit_select #(.N(BANK_CNT), .ADDR_W(ADDR_W)) u_sel (
    .bank_hit (bank_hit),
    .bank_off (bank_off),
    .hit      (hit),
    .miss     (miss),
    .idx      (hit_bank),
    .off      (hit_offset)
  );

endmodule

// File: rtl/bmd_checker.sv
module bmd_checker
  import bmd_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int BANK_CNT      = 4,
  parameter int INST_MIN_LOG2 = 21,
  localparam int SEL_W        = idx_w(BANK_CNT / 2),
  localparam int IDX_W        = idx_w(BANK_CNT),
  localparam int MAP_W        = BANK_CNT * INST_NIB_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_wr_en,
  input logic [SEL_W-1:0]     cfg_wr_sel,
  input logic [CFG_REG_W-1:0] cfg_wr_data,
  input logic [SEL_W-1:0]     cfg_rd_sel,
  input logic [CFG_REG_W-1:0] cfg_rd_data,
  input logic [MAP_W-1:0]     inst_map,
  input logic                 hit,
  input logic                 miss,
  input logic [IDX_W-1:0]     hit_bank,
  input logic [ADDR_W-1:0]    hit_offset
);

  logic [INST_CODE_W-1:0] win_code;
  logic [ADDR_W+1:0]      win_bytes;
  assign win_code  = inst_map[int'(hit_bank)*INST_NIB_W +: INST_CODE_W];
  assign win_bytes = (ADDR_W+2)'(1) << (INST_MIN_LOG2 + int'(win_code));

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cfg_rd_data == '0 && miss));

  p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en ##1 (cfg_rd_sel == $past(cfg_wr_sel)) |-> cfg_rd_data == $past(cfg_wr_data));

  p_populated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> win_code != '0);

  p_hit_xor_miss_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hit != miss);

  p_miss_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (hit_offset == '0 && hit_bank == '0));

  p_offset_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (ADDR_W+2)'(hit_offset) < win_bytes);

endmodule

bind bank_map_decoder bmd_checker #(
  .ADDR_W        (ADDR_W),
  .BANK_CNT      (BANK_CNT),
  .INST_MIN_LOG2 (INST_MIN_LOG2)
) u_bmd_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr_en   (cfg_wr_en),
  .cfg_wr_sel  (cfg_wr_sel),
  .cfg_wr_data (cfg_wr_data),
  .cfg_rd_sel  (cfg_rd_sel),
  .cfg_rd_data (cfg_rd_data),
  .inst_map    (inst_map),
  .hit         (hit),
  .miss        (miss),
  .hit_bank    (hit_bank),
  .hit_offset  (hit_offset)
);

// File: tb/bank_map_decoder_test.sv
`timescale 1ns/1ps
module bank_map_decoder_test;

  localparam int CLK_NS = 8;
  localparam longint MIB = 64'd1 << 20;

  logic        clk;
  logic        rst_n;
  logic        cfg_wr_en;
  logic        cfg_wr_sel;
  logic [31:0] cfg_wr_data;
  logic        cfg_rd_sel;
  logic [31:0] cfg_rd_data;
  logic [15:0] inst_map;
  logic [31:0] probe_addr;
  logic        hit;
  logic        miss;
  logic [1:0]  hit_bank;
  logic [31:0] hit_offset;

  int checks = 0;
  int failures = 0;
  logic [31:0] sh0, sh1;

  bank_map_decoder uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
    .cfg_wr_data(cfg_wr_data), .cfg_rd_sel(cfg_rd_sel), .cfg_rd_data(cfg_rd_data),
    .inst_map(inst_map), .probe_addr(probe_addr), .hit(hit), .miss(miss),
    .hit_bank(hit_bank), .hit_offset(hit_offset)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  // Behavioural model written from the requirements
  function automatic void model(input logic [31:0] w0, input logic [31:0] w1,
                                input logic [15:0] map, input longint a,
                                output bit eh, output int eb, output longint eo);
    eh = 0; eb = 0; eo = 0;
    for (int b = 0; b < 4; b++) begin
      logic [15:0] h;
      longint base, csz, isz, eff, start;
      int code, nr;
      bit cd, id;
      case (b)
        0: h = w0[31:16];
        1: h = w0[15:0];
        2: h = w1[31:16];
        default: h = w1[15:0];
      endcase
      code = int'(map[b*4 +: 3]);
      if (!h[13] || code == 0) continue;
      cd   = h[14];
      id   = map[b*4+3];
      base = longint'(h[7:0]) * 4 * MIB;
      csz  = (longint'(h[12:8]) + 1) * 4 * MIB;
      if (cd) csz = csz / 2;
      isz  = longint'(1) << (code + 21);
      if (id) isz = isz / 2;
      nr   = (cd && id) ? 2 : 1;
      eff  = (csz < isz) ? csz : isz;
      for (int r = 0; r < nr; r++) begin
        start = base + r * csz;
        if (a >= start && a < start + csz) begin
          eh = 1; eb = b; eo = ((a - start) % eff) + r * eff;
          return;
        end
      end
      if (h[7:0] == 8'h20 && a < 64'h80000) begin
        eh = 1; eb = b; eo = a;
        return;
      end
    end
  endfunction

  task automatic probe(input longint a, input string tag);
    bit eh; int eb; longint eo; bit bad;
    @(negedge clk);
    probe_addr = a[31:0];
    #3;
    model(sh0, sh1, inst_map, a, eh, eb, eo);
    checks++;
    if (eh) bad = (hit !== 1'b1) || (miss !== 1'b0) || (hit_bank !== 2'(eb)) || (hit_offset !== eo[31:0]);
    else    bad = (hit !== 1'b0) || (miss !== 1'b1) || (hit_bank !== 2'd0) || (hit_offset !== 32'd0);
    if (bad) begin
      failures++;
      $display("FAIL %s addr=%h actual hit=%b miss=%b bank=%0d off=%h expected hit=%b bank=%0d off=%h",
               tag, a[31:0], hit, miss, hit_bank, hit_offset, eh, eb, eo[31:0]);
    end
  endtask

  task automatic sweep(input longint base, input string tag);
    longint offs[16] = '{0, 1, 2*MIB-1, 2*MIB, 4*MIB-1, 4*MIB, 8*MIB-1, 8*MIB,
                         12*MIB, 16*MIB-1, 16*MIB, 24*MIB-1, 24*MIB, 32*MIB-1, 32*MIB, 40*MIB};
    probe(base - 1, tag);
    foreach (offs[i]) probe(base + offs[i], tag);
    for (int k = 0; k < 24; k++) probe(base + longint'($urandom_range(0, 48*1024*1024)), tag);
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    if (sel) sh1 = d; else sh0 = d;
  endtask

  task automatic rdchk(input logic sel, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    cfg_rd_sel = sel;
    #3;
    exp = sel ? sh1 : sh0;
    checks++;
    if (cfg_rd_data !== exp) begin
      failures++;
      $display("FAIL %s readback word %0d actual=%h expected=%h", tag, sel, cfg_rd_data, exp);
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    failures++;
    $display("FAIL watchdog R2 actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_sel = 1'b0; cfg_wr_data = '0;
    cfg_rd_sel = 1'b0; inst_map = 16'h0000; probe_addr = '0;
    sh0 = '0; sh1 = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: cleared words, every address misses
    inst_map = 16'hBBBB;
    rdchk(1'b0, "R1"); rdchk(1'b1, "R1");
    probe(0, "R1"); probe(64'h0800_0000, "R1"); probe(64'h1000_0000, "R1");

    // R5, R9, R3: bank 0 single/single, 16 MiB window over 4 MiB, base 0x0800_0000
    inst_map = 16'h0001;
    wr(1'b0, 32'h2320_0000);
    probe(64'h0800_0000, "R2");
    rdchk(1'b0, "R3");
    sweep(64'h0800_0000, "R5");
    probe(0, "R9"); probe(64'h7FFFC, "R9"); probe(64'h80000, "R9"); probe(64'h1234, "R9");

    // R6: bank 1 dual/dual, 32 MiB window over 16 MiB dual
    inst_map = 16'h00B0;
    wr(1'b0, 32'h0000_6740);
    rdchk(1'b0, "R3");
    sweep(64'h1000_0000, "R6");
    probe(0, "R9");

    // R7: bank 2 dual programmed, single 8 MiB fitted
    inst_map = 16'h0200;
    wr(1'b0, 32'h0000_0000);
    wr(1'b1, 32'h6760_0000);
    rdchk(1'b1, "R3");
    sweep(64'h1800_0000, "R7");

    // R8: bank 3 single programmed, 16 MiB dual fitted
    inst_map = 16'hB000;
    wr(1'b1, 32'h0000_2380);
    rdchk(1'b1, "R3");
    sweep(64'h2000_0000, "R8");

    // R10: banks 0 and 2 share base 0x0800_0000
    inst_map = 16'h0201;
    wr(1'b0, 32'h2120_0000);
    wr(1'b1, 32'h2320_0000);
    sweep(64'h0800_0000, "R10");
    probe(0, "R10"); probe(64'h4_0000, "R10");

    // R4: enabled but empty bank 0, populated but disabled bank 2
    inst_map = 16'h0200;
    wr(1'b0, 32'h2320_0000);
    wr(1'b1, 32'h0360_0000);
    sweep(64'h0800_0000, "R4");
    sweep(64'h1800_0000, "R4");
    probe(0, "R4");

    // R11: miss outputs with all banks disabled again
    wr(1'b0, 32'h0000_0000);
    wr(1'b1, 32'h0000_0000);
    rdchk(1'b0, "R2"); rdchk(1'b1, "R2");
    probe(64'h0800_0000, "R11"); probe(64'hFFFF_FFFF, "R11");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule